// File: doc/BRIEF.md
# Distributed DRAM Refresh Scheduler

This block keeps every row of a dynamic memory alive by issuing one single-row refresh cycle at a fixed interval. The interval equals the retention window in clocks divided by the row count, so all rows are covered once per window; a 64 ms window is the usual target. The refreshes are spread out instead of being issued as one burst, which keeps each stall of the access path short.

A free-running timer marks each refresh slot. A slot makes a refresh owed, and the scheduler then raises a request to the access sequencer. The refresh starts on a cycle where the grant is high and no access is busy. At most one refresh can be owed. If a second slot passes while one is still owed, a status flag reports that refresh as late.

Two refresh styles are selectable per refresh. In row-addressed mode the scheduler places its own row counter on the address bus, lowers RAS with CAS held high, and advances the counter afterwards. In CAS-first mode it lowers CAS one cycle ahead of RAS. The memory then uses its internal counter, so the scheduler's address bus stays at zero and its row counter is left untouched.

Top module: `refresh_sched`

## Requirements
- R1: While rst_ni is low, ras_no and cas_no are 1, and req_o, late_o and addr_o are 0.
- R2: With grant_i=1 and busy_i=0 held, RAS falling edges occur exactly INTERVAL clock cycles apart.
- R3: In row-addressed mode (cbr_mode_i=0), cas_no stays 1 throughout the refresh. addr_o carries the row number in the cycle before ras_no falls and stays unchanged at the fall.
- R4: The row counter starts at 0 after reset. It advances by one after each row-addressed refresh and wraps from NUM_ROWS-1 to 0.
- R5: In CAS-first mode (cbr_mode_i=1), cas_no is 0 in the cycle before ras_no falls and stays 0 while ras_no is 0. Both return to 1 on the same clock. addr_o is 0 throughout.
- R6: A CAS-first refresh leaves the row counter unchanged, so the next row-addressed refresh uses the row that would have come next.
- R7: ras_no stays 0 for exactly RAS_LOW clock cycles per refresh.
- R8: req_o is 1 whenever a refresh is owed and none is in progress. A refresh starts only on a clock where grant_i=1 and busy_i=0, and req_o is 0 in the cycle after the start.
- R9: If a refresh is owed while busy_i=1, ras_no stays 1. ras_no falls in the second cycle after the clock that first samples busy_i=0.
- R10: At most one refresh is owed. A slot that passes while a refresh is still owed sets late_o to 1, and late_o returns to 0 on the clock that starts that refresh.
- R11: cbr_mode_i is sampled on the clock that starts a refresh; a change during the refresh does not alter its strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cbr_mode_i | input | 1 | 1 selects CAS-first refresh, 0 selects row-addressed refresh |
| grant_i | input | 1 | Access sequencer grants the bus to refresh |
| busy_i | input | 1 | An access is in progress |
| req_o | output | 1 | Refresh owed and scheduler idle |
| ras_no | output | 1 | Row strobe, active low |
| cas_no | output | 1 | Column strobe, active low |
| addr_o | output | $clog2(NUM_ROWS) | Row address during row-addressed refresh, else 0 |
| late_o | output | 1 | Owed refresh has missed a slot |

## Verification
A start is taken on the clock that sees an owed refresh, grant_i high and busy_i low. The following cycle is the setup cycle, in which only the address or CAS is active. RAS falls in the cycle after that and rises RAS_LOW cycles later. late_o and req_o change on the start clock itself.

The bench drives inputs on falling edges and samples on falling edges. A busy release is therefore expected to show RAS high at the first sample and low at the second. Each RAS fall pops one expected refresh, holding the mode and row, from a queue filled by the driver. Periods and low widths are measured in sampled cycles between falls and rises.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE
  } seq_state_e;
endpackage

// File: rtl/refresh_timer.sv
module refresh_timer #(
  parameter int INTERVAL = 24
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = (cnt_q == CNT_W'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/refresh_owe.sv
module refresh_owe (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic start_i,
  output logic owe_o,
  output logic late_o
);
  logic owe_q, late_q;

  assign owe_o  = owe_q;
  assign late_o = late_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owe_q  <= 1'b0;
      late_q <= 1'b0;
    end else begin
      // a new slot wins over the clear; only one refresh is ever owed
      owe_q <= tick_i | (owe_q & ~start_i);
      if (start_i) late_q <= 1'b0;
      else if (tick_i && owe_q) late_q <= 1'b1;
    end
  end
endmodule

// File: rtl/refresh_seq.sv
module refresh_seq
  import refresh_sched_pkg::*;
#(
  parameter int NUM_ROWS = 16,
  parameter int RAS_LOW  = 3,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             owe_i,
  input  logic             grant_i,
  input  logic             busy_i,
  input  logic             cbr_mode_i,
  output logic             start_o,
  output logic             req_o,
  output logic             ras_no,
  output logic             cas_no,
  output logic [ROW_W-1:0] addr_o
);
  localparam int PH_W = (RAS_LOW > 1) ? $clog2(RAS_LOW) : 1;

  seq_state_e       state_q;
  logic             cbr_q;
  logic [PH_W-1:0]  ph_q;
  logic [ROW_W-1:0] row_q;
  logic             active;

  assign active  = (state_q != ST_IDLE);
  assign start_o = owe_i && grant_i && !busy_i && !active;
  assign req_o   = owe_i && !active;
  assign ras_no  = (state_q != ST_STROBE);
  assign cas_no  = !(cbr_q && active);
  assign addr_o  = (active && !cbr_q) ? row_q : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cbr_q   <= 1'b0;
      ph_q    <= '0;
      row_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (start_o) begin
            state_q <= ST_SETUP;
            cbr_q   <= cbr_mode_i;
          end
        end
        ST_SETUP: begin
          state_q <= ST_STROBE;
          ph_q    <= '0;
        end
        ST_STROBE: begin
          if (ph_q == PH_W'(RAS_LOW - 1)) begin
            state_q <= ST_IDLE;
            // in CAS-first mode the memory counts; ours holds
            if (!cbr_q)
              row_q <= (row_q == ROW_W'(NUM_ROWS - 1)) ? '0 : row_q + 1'b1;
          end else begin
            ph_q <= ph_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
  parameter int NUM_ROWS = 16,
  parameter int INTERVAL = 24,
  parameter int RAS_LOW  = 3,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cbr_mode_i,
  input  logic             grant_i,
  input  logic             busy_i,
  output logic             req_o,
  output logic             ras_no,
  output logic             cas_no,
  output logic [ROW_W-1:0] addr_o,
  output logic             late_o
);
  logic tick, owe, start;

  refresh_timer #(.INTERVAL(INTERVAL)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_o (tick)
  );

  refresh_owe u_owe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .start_i (start),
    .owe_o   (owe),
    .late_o  (late_o)
  );

  refresh_seq #(.NUM_ROWS(NUM_ROWS), .RAS_LOW(RAS_LOW)) u_seq (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .owe_i      (owe),
    .grant_i    (grant_i),
    .busy_i     (busy_i),
    .cbr_mode_i (cbr_mode_i),
    .start_o    (start),
    .req_o      (req_o),
    .ras_no     (ras_no),
    .cas_no     (cas_no),
    .addr_o     (addr_o)
  );
endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int NUM_ROWS = 16,
  parameter int RAS_LOW  = 3,
  localparam int ROW_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             grant_i,
  input logic             busy_i,
  input logic             req_o,
  input logic             ras_no,
  input logic             cas_no,
  input logic [ROW_W-1:0] addr_o,
  input logic             late_o
);
  localparam int LW = $clog2(RAS_LOW + 2);

  logic [LW-1:0] low_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) low_cnt_q <= '0;
    else if (ras_no) low_cnt_q <= '0;
    else low_cnt_q <= low_cnt_q + 1'b1;
  end

  p_ror_addr_stable_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && cas_no) |-> (addr_o == $past(addr_o)));

  p_cbr_cas_first_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ras_no) && !cas_no) |-> $past(!cas_no));

  p_cbr_no_addr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cas_no |-> (addr_o == '0));

  p_ras_width_max_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ras_no |-> (low_cnt_q < LW'(RAS_LOW)));

  p_ras_width_exact_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ras_no) |-> (low_cnt_q == LW'(RAS_LOW)));

  p_busy_blocks_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && busy_i) |=> (ras_no && cas_no));

  p_req_drop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && grant_i && !busy_i) |=> !req_o);

  p_late_owed_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    late_o |-> req_o);
endmodule

bind refresh_sched refresh_sched_chk #(.NUM_ROWS(NUM_ROWS), .RAS_LOW(RAS_LOW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .grant_i (grant_i),
  .busy_i  (busy_i),
  .req_o   (req_o),
  .ras_no  (ras_no),
  .cas_no  (cas_no),
  .addr_o  (addr_o),
  .late_o  (late_o)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;
  localparam int NUM_ROWS = 16;
  localparam int INTERVAL = 24;
  localparam int RAS_LOW  = 3;
  localparam int ROW_W    = $clog2(NUM_ROWS);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cbr_mode_i = 1'b0;
  logic grant_i = 1'b1;
  logic busy_i = 1'b0;
  logic req_o, ras_no, cas_no, late_o;
  logic [ROW_W-1:0] addr_o;

  always #4 clk = ~clk;

  refresh_sched #(.NUM_ROWS(NUM_ROWS), .INTERVAL(INTERVAL), .RAS_LOW(RAS_LOW)) uut (
    .clk_i (clk), .rst_ni (rst_ni), .cbr_mode_i (cbr_mode_i), .grant_i (grant_i),
    .busy_i (busy_i), .req_o (req_o), .ras_no (ras_no), .cas_no (cas_no),
    .addr_o (addr_o), .late_o (late_o)
  );

  typedef struct { bit cbr; int row; } exp_t;
  exp_t exp_q[$];

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int exp_row = 0;
  bit chk_period = 1'b0;
  bit done = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // monitor: every RAS fall consumes one expected refresh
  bit prev_ras = 1'b1, prev_cas = 1'b1, last_valid = 1'b0;
  logic [ROW_W-1:0] prev_addr = '0;
  int last_fall = 0, fall_cyc = 0;
  exp_t cur;
  always @(negedge clk) begin
    cyc++;
    if (rst_ni) begin
      if (prev_ras && !ras_no) begin
        fall_cyc = cyc;
        if (chk_period && last_valid)
          check(cyc - last_fall == INTERVAL, "R2 refresh spacing", cyc - last_fall, INTERVAL);
        last_valid = chk_period;
        last_fall = cyc;
        if (exp_q.size() == 0) begin
          check(1'b0, "R10 unexpected refresh", 1, 0);
        end else begin
          cur = exp_q.pop_front();
          if (cur.cbr) begin
            check(prev_cas == 1'b0, "R5 CAS low before RAS", int'(prev_cas), 0);
            check(cas_no == 1'b0, "R5 CAS low at RAS fall", int'(cas_no), 0);
            check(addr_o == '0, "R5 address zero", int'(addr_o), 0);
          end else begin
            check(cas_no == 1'b1, "R3 CAS high", int'(cas_no), 1);
            check(int'(prev_addr) == cur.row, "R3 address setup", int'(prev_addr), cur.row);
            check(int'(addr_o) == cur.row, "R4 row address", int'(addr_o), cur.row);
          end
        end
      end
      if (!prev_ras && ras_no) begin
        check(cyc - fall_cyc == RAS_LOW, "R7 RAS low width", cyc - fall_cyc, RAS_LOW);
        check(cas_no == 1'b1, "R5 strobes release together", int'(cas_no), 1);
      end
    end
    prev_ras = ras_no;
    prev_cas = cas_no;
    prev_addr = addr_o;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  task automatic push_ref(input bit cbr);
    exp_t e;
    e.cbr = cbr;
    e.row = cbr ? 0 : exp_row;
    exp_q.push_back(e);
    if (!cbr) exp_row = (exp_row + 1) % NUM_ROWS;
  endtask

  task automatic wait_drain(input string tag, input int limit);
    int n = 0;
    while (exp_q.size() != 0 && n < limit) begin
      @(negedge clk);
      n++;
    end
    check(exp_q.size() == 0, tag, exp_q.size(), 0);
  endtask

  task automatic run_refs(input bit cbr, input int n, input string tag);
    for (int i = 0; i < n; i++) push_ref(cbr);
    wait_drain(tag, n * INTERVAL + 40);
  endtask

  task automatic wait_req(input string tag);
    int n = 0;
    while (!req_o && n < 4 * INTERVAL) begin
      @(negedge clk);
      n++;
    end
    check(req_o == 1'b1, tag, int'(req_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ras_no == 1'b1, "R1 ras_no in reset", int'(ras_no), 1);
    check(cas_no == 1'b1, "R1 cas_no in reset", int'(cas_no), 1);
    check(req_o == 1'b0, "R1 req_o in reset", int'(req_o), 0);
    check(late_o == 1'b0, "R1 late_o in reset", int'(late_o), 0);
    check(addr_o == '0, "R1 addr_o in reset", int'(addr_o), 0);
    rst_ni = 1'b1;
    chk_period = 1'b1;

    // R2 R3 R4: row-addressed, past the wrap
    run_refs(1'b0, NUM_ROWS + 2, "R4 row-addressed run drained");

    // R5: CAS-first
    cbr_mode_i = 1'b1;
    run_refs(1'b1, 3, "R5 CAS-first run drained");
    // R11: mode change mid-refresh has no effect
    cbr_mode_i = 1'b0;
    @(negedge clk);
    check(cas_no == 1'b0, "R11 CAS kept after mode change", int'(cas_no), 0);
    check(ras_no == 1'b0, "R11 RAS still low", int'(ras_no), 0);

    // R6: counter resumes where it left off
    run_refs(1'b0, 2, "R6 row-addressed resumes");

    // R8 R9: busy holds an owed refresh
    chk_period = 1'b0;
    busy_i = 1'b1;
    wait_req("R8 request raised while busy");
    push_ref(1'b0);
    repeat (5) @(negedge clk);
    check(ras_no == 1'b1, "R9 no refresh while busy", int'(ras_no), 1);
    check(req_o == 1'b1, "R8 request held while busy", int'(req_o), 1);
    busy_i = 1'b0;
    @(negedge clk);
    check(ras_no == 1'b1, "R9 setup cycle after busy", int'(ras_no), 1);
    check(req_o == 1'b0, "R8 request drops after start", int'(req_o), 0);
    @(negedge clk);
    check(ras_no == 1'b0, "R9 RAS falls 2 cycles after busy", int'(ras_no), 0);
    wait_drain("R9 owed refresh issued", 10);

    // R10: missed slot sets late, only one refresh owed
    grant_i = 1'b0;
    wait_req("R10 request without grant");
    repeat (INTERVAL + 2) @(negedge clk);
    check(late_o == 1'b1, "R10 late after missed slot", int'(late_o), 1);
    check(ras_no == 1'b1, "R8 no refresh without grant", int'(ras_no), 1);
    push_ref(1'b0);
    grant_i = 1'b1;
    @(negedge clk);
    check(late_o == 1'b0, "R10 late clears on start", int'(late_o), 0);
    wait_drain("R10 single owed refresh", 10);
    repeat (RAS_LOW + 2) @(negedge clk);
    check(req_o == 1'b0, "R10 no second owed refresh", int'(req_o), 0);
    run_refs(1'b0, 1, "R10 schedule resumes");

    repeat (5) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule